// File: doc/BRIEF.md
# Reference-Timed Clock Frequency Counter

This block estimates the rate of an arbitrary clock by counting its rising edges for a known number of cycles of the reference clock. A command word carries a reference tick count and a run flag. A write with the run flag clear stops counting and arms the timer. A write with the flag set opens the counting window. Software polls a status word: a flag that reads clear when a run may start and set when the result is ready, plus the captured edge count.

The edge counter sits in the measured clock's domain, so it only clears when that clock is toggling. A stopped clock therefore leaves its last count in place. A built-in probe sequencer uses this. On one request it runs a short window and then a long one, and reports the long count. It also raises an "off" flag when both counts are equal, which means the measured clock never moved. Converting the count to hertz is done by the consumer.

The gate and clear controls cross into the measured domain through synchronizers. The count comes back Gray-coded through a synchronizer and is sampled only after a settle window, once it has frozen.

Top module: `fmeter_top`

## Requirements
- R1: After reset the status word is all zero, and `probe_busy` and `probe_valid` are low.
- R2: A command write with bit 20 clear and the tick count in bits 19:0 makes status bit 25 read 1 from the next cycle, for SETTLE_CYC cycles. Status bit 25 then reads 0 (ready). While the measured clock runs, that period clears the edge counter.
- R3: A command write with bit 20 set, made while status bit 25 is 0, counts measured-clock rising edges for the given number of reference cycles. Status bit 25 then becomes 1, and status bits 24:0 hold the count, within ±2 of ticks × Tref / Tmeas.
- R4: A command write with bit 20 set, made while status bit 25 is 1, is ignored: the status word does not change and no counting starts.
- R5: While status bit 25 stays 1 and no command is written, the status word is stable.
- R6: If the measured clock is stopped, a load and run returns the previous count unchanged, because the counter cannot clear.
- R7: A pulse on `probe_go` runs a pass of SHORT_TICKS and then a pass of FULL_TICKS. It then pulses `probe_valid` for one cycle, with `probe_count` equal to the full-pass count. `probe_busy` is high throughout the sequence.
- R8: `probe_off` is 1 exactly when the short-pass and full-pass counts are equal.
- R9: External command writes are ignored while `probe_busy` is high.
- R10: A `probe_go` pulse while `probe_busy` is high is ignored and produces no extra result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset (reference domain) |
| meas_clk | input | 1 | Clock under measurement |
| ext_we | input | 1 | Command write strobe |
| ext_wdata | input | TICK_W+1 | Command: bit TICK_W = run flag, low bits = tick count |
| status | output | CNT_W+1 | Bit CNT_W = not-ready/done flag, low bits = captured count |
| probe_go | input | 1 | Start a two-pass probe |
| probe_busy | output | 1 | Probe sequence in progress |
| probe_valid | output | 1 | One-cycle result strobe |
| probe_count | output | CNT_W | Full-pass edge count |
| probe_off | output | 1 | Measured clock judged stopped |

## Verification
The bench builds the block with SHORT_TICKS=32 and FULL_TICKS=128, and keeps SETTLE_CYC=8 and the 25-bit count. With these values a full two-pass probe finishes in a few hundred cycles, so one run can cover three measured-clock periods, a halted measured clock, and mid-probe interference. The measured clock is held for part of the run, which exposes the stale-count path and the "off" verdict. The counter's direct command interface is exercised before the probe sequencer.

// File: rtl/fmeter_pkg.sv
package fmeter_pkg;

    typedef enum logic [2:0] {
        ST_ARMED,
        ST_CLEAR,
        ST_RUN,
        ST_SETTLE,
        ST_DONE
    } eng_state_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_LOAD,
        SQ_WAIT_RDY,
        SQ_RUN,
        SQ_WAIT_DONE,
        SQ_STOP
    } seq_state_e;

    // Counts up to 32 bits wide travel through these helpers.
    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/fmeter_sync.sv
module fmeter_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        stg[0] <= d;
        for (int i = 1; i < STAGES; i++) begin
            stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/fmeter_edge_cnt.sv
module fmeter_edge_cnt
    import fmeter_pkg::*;
#(
    parameter int CNT_W       = 25,
    parameter int SYNC_STAGES = 2
) (
    input  logic             mclk,
    input  logic             rst,
    input  logic             gate,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt_gray
);
    logic             m_rst;
    logic [1:0]       ctl_s;
    logic [CNT_W-1:0] cnt;

    fmeter_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rst_sync (
        .clk(mclk), .d(rst), .q(m_rst)
    );

    fmeter_sync #(.W(2), .STAGES(SYNC_STAGES)) u_ctl_sync (
        .clk(mclk), .d({gate, clr}), .q(ctl_s)
    );

    always_ff @(posedge mclk) begin
        if (m_rst) begin
            cnt      <= '0;
            cnt_gray <= '0;
        end else begin
            if (ctl_s[0]) begin
                cnt <= '0;
            end else if (ctl_s[1]) begin
                cnt <= cnt + CNT_W'(1);
            end
            cnt_gray <= CNT_W'(bin2gray(32'(cnt)));
        end
    end
endmodule

// File: rtl/fmeter_engine.sv
module fmeter_engine
    import fmeter_pkg::*;
#(
    parameter int CNT_W      = 25,
    parameter int TICK_W     = 20,
    parameter int SETTLE_CYC = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [TICK_W:0]   wdata,
    input  logic [CNT_W-1:0]  cnt_bin,
    output logic              gate,
    output logic              clr,
    output logic [CNT_W:0]    status
);
    localparam int WW = $clog2(SETTLE_CYC + 1);

    eng_state_e        st, st_n;
    logic [TICK_W-1:0] tcnt;
    logic [WW-1:0]     wcnt;
    logic [CNT_W-1:0]  cnt_q;
    logic              run_flag;
    logic [TICK_W-1:0] ticks;

    assign run_flag = wdata[TICK_W];
    assign ticks    = wdata[TICK_W-1:0];

    always_comb begin
        st_n = st;
        if (we && !run_flag) begin
            st_n = ST_CLEAR;
        end else if (we && run_flag && st == ST_ARMED) begin
            st_n = ST_RUN;
        end else begin
            case (st)
                ST_CLEAR:  if (wcnt == WW'(SETTLE_CYC - 1)) st_n = ST_ARMED;
                ST_RUN:    if (tcnt <= TICK_W'(1))          st_n = ST_SETTLE;
                ST_SETTLE: if (wcnt == WW'(SETTLE_CYC - 1)) st_n = ST_DONE;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_ARMED;
            gate  <= 1'b0;
            clr   <= 1'b0;
            tcnt  <= '0;
            wcnt  <= '0;
            cnt_q <= '0;
        end else begin
            st   <= st_n;
            gate <= (st_n == ST_RUN);
            clr  <= (st_n == ST_CLEAR);
            wcnt <= (st_n != st || we) ? '0 : wcnt + WW'(1);
            if (we) begin
                tcnt <= ticks;
            end else if (st == ST_RUN) begin
                tcnt <= tcnt - TICK_W'(1);
            end
            if (st == ST_SETTLE && st_n == ST_DONE) begin
                cnt_q <= cnt_bin;
            end
        end
    end

    assign status = {(st == ST_CLEAR) || (st == ST_DONE), cnt_q};
endmodule

// File: rtl/fmeter_seq.sv
module fmeter_seq
    import fmeter_pkg::*;
#(
    parameter int CNT_W       = 25,
    parameter int TICK_W      = 20,
    parameter int SHORT_TICKS = 4096,
    parameter int FULL_TICKS  = 65536
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [CNT_W:0]   status,
    output logic             busy,
    output logic             we,
    output logic [TICK_W:0]  wdata,
    output logic             valid,
    output logic [CNT_W-1:0] count,
    output logic             off
);
    localparam logic [TICK_W-1:0] SHORT_V = TICK_W'(SHORT_TICKS);
    localparam logic [TICK_W-1:0] FULL_V  = TICK_W'(FULL_TICKS);

    seq_state_e        sq;
    logic              pass;
    logic [CNT_W-1:0]  short_q;
    logic [CNT_W-1:0]  full_q;
    logic [TICK_W-1:0] ticks_sel;

    assign ticks_sel = pass ? FULL_V : SHORT_V;
    assign busy      = (sq != SQ_IDLE);
    assign we        = (sq == SQ_LOAD) || (sq == SQ_RUN) || (sq == SQ_STOP);
    assign count     = full_q;

    always_comb begin
        case (sq)
            SQ_LOAD: wdata = {1'b0, ticks_sel};
            SQ_RUN:  wdata = {1'b1, ticks_sel};
            default: wdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sq      <= SQ_IDLE;
            pass    <= 1'b0;
            short_q <= '0;
            full_q  <= '0;
            valid   <= 1'b0;
            off     <= 1'b0;
        end else begin
            valid <= 1'b0;
            case (sq)
                SQ_IDLE: if (go) begin
                    pass <= 1'b0;
                    sq   <= SQ_LOAD;
                end
                SQ_LOAD:     sq <= SQ_WAIT_RDY;
                SQ_WAIT_RDY: if (!status[CNT_W]) sq <= SQ_RUN;
                SQ_RUN:      sq <= SQ_WAIT_DONE;
                SQ_WAIT_DONE: if (status[CNT_W]) begin
                    if (pass) begin
                        full_q <= status[CNT_W-1:0];
                        sq     <= SQ_STOP;
                    end else begin
                        short_q <= status[CNT_W-1:0];
                        pass    <= 1'b1;
                        sq      <= SQ_LOAD;
                    end
                end
                SQ_STOP: begin
                    valid <= 1'b1;
                    off   <= (full_q == short_q);
                    sq    <= SQ_IDLE;
                end
                default: sq <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fmeter_top.sv
module fmeter_top
    import fmeter_pkg::*;
#(
    parameter int CNT_W       = 25,
    parameter int TICK_W      = 20,
    parameter int SYNC_STAGES = 2,
    parameter int SETTLE_CYC  = 8,
    parameter int SHORT_TICKS = 4096,
    parameter int FULL_TICKS  = 65536
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             meas_clk,
    input  logic             ext_we,
    input  logic [TICK_W:0]  ext_wdata,
    output logic [CNT_W:0]   status,
    input  logic             probe_go,
    output logic             probe_busy,
    output logic             probe_valid,
    output logic [CNT_W-1:0] probe_count,
    output logic             probe_off
);
    logic             seq_we;
    logic [TICK_W:0]  seq_wdata;
    logic             eng_we;
    logic [TICK_W:0]  eng_wdata;
    logic             eng_gate;
    logic             eng_clr;
    logic [CNT_W-1:0] cnt_gray;
    logic [CNT_W-1:0] cnt_gray_s;
    logic [CNT_W-1:0] cnt_bin;

    // The probe sequencer owns the command port while it is busy.
    assign eng_we    = probe_busy ? seq_we    : ext_we;
    assign eng_wdata = probe_busy ? seq_wdata : ext_wdata;

    fmeter_edge_cnt #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_edge (
        .mclk(meas_clk), .rst(rst), .gate(eng_gate), .clr(eng_clr),
        .cnt_gray(cnt_gray)
    );

    fmeter_sync #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_cnt_sync (
        .clk(clk), .d(cnt_gray), .q(cnt_gray_s)
    );

    assign cnt_bin = CNT_W'(gray2bin(32'(cnt_gray_s)));

    fmeter_engine #(.CNT_W(CNT_W), .TICK_W(TICK_W), .SETTLE_CYC(SETTLE_CYC)) u_eng (
        .clk(clk), .rst(rst), .we(eng_we), .wdata(eng_wdata),
        .cnt_bin(cnt_bin), .gate(eng_gate), .clr(eng_clr), .status(status)
    );

    fmeter_seq #(
        .CNT_W(CNT_W), .TICK_W(TICK_W),
        .SHORT_TICKS(SHORT_TICKS), .FULL_TICKS(FULL_TICKS)
    ) u_seq (
        .clk(clk), .rst(rst), .go(probe_go), .status(status),
        .busy(probe_busy), .we(seq_we), .wdata(seq_wdata),
        .valid(probe_valid), .count(probe_count), .off(probe_off)
    );
endmodule

// File: rtl/fmeter_checker.sv
module fmeter_checker #(
    parameter int CNT_W  = 25,
    parameter int TICK_W = 20
) (
    input logic            clk,
    input logic            rst,
    input logic            we,
    input logic [TICK_W:0] wdata,
    input logic [CNT_W:0]  status,
    input logic            gate,
    input logic            valid,
    input logic            busy
);
    a_r2_load_not_ready: assert property (@(posedge clk) disable iff (rst)
        (we && !wdata[TICK_W]) |=> status[CNT_W]);

    a_r3_gate_only_when_ready: assert property (@(posedge clk) disable iff (rst)
        gate |-> !status[CNT_W]);

    a_r4_run_ignored_when_busy: assert property (@(posedge clk) disable iff (rst)
        (we && wdata[TICK_W] && status[CNT_W]) |=> !gate);

    a_r5_status_holds: assert property (@(posedge clk) disable iff (rst)
        (status[CNT_W] && $past(status[CNT_W]) && !$past(we)) |-> $stable(status));

    a_r7_valid_single: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    a_r7_valid_after_busy: assert property (@(posedge clk) disable iff (rst)
        valid |-> $past(busy));
endmodule

bind fmeter_top fmeter_checker #(.CNT_W(CNT_W), .TICK_W(TICK_W)) u_fmeter_chk (
    .clk(clk), .rst(rst), .we(eng_we), .wdata(eng_wdata), .status(status),
    .gate(eng_gate), .valid(probe_valid), .busy(probe_busy)
);

// File: tb/test_fmeter_top.sv
`timescale 1ns/1ps
module test_fmeter_top;
    localparam int CNT_W  = 25;
    localparam int TICK_W = 20;
    localparam int SHORT  = 32;
    localparam int FULL   = 128;
    localparam real TREF  = 8.0;

    typedef struct {
        int    cnt;
        int    tol;
        bit    off;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             meas_clk = 1'b0;
    logic             ext_we = 1'b0;
    logic [TICK_W:0]  ext_wdata = '0;
    logic [CNT_W:0]   status;
    logic             probe_go = 1'b0;
    logic             probe_busy;
    logic             probe_valid;
    logic [CNT_W-1:0] probe_count;
    logic             probe_off;

    int   checks = 0;
    int   fails = 0;
    int   pushed = 0;
    int   valid_seen = 0;
    bit   m_run = 1'b1;
    real  mhalf = 3.0;
    bit   done_flag = 1'b0;
    exp_t sb_q[$];

    fmeter_top #(
        .CNT_W(CNT_W), .TICK_W(TICK_W), .SYNC_STAGES(2), .SETTLE_CYC(8),
        .SHORT_TICKS(SHORT), .FULL_TICKS(FULL)
    ) i_fmeter_top (
        .clk(clk), .rst(rst), .meas_clk(meas_clk), .ext_we(ext_we),
        .ext_wdata(ext_wdata), .status(status), .probe_go(probe_go),
        .probe_busy(probe_busy), .probe_valid(probe_valid),
        .probe_count(probe_count), .probe_off(probe_off)
    );

    always #4 clk = ~clk;

    initial begin
        forever begin
            #(mhalf);
            if (m_run) meas_clk = ~meas_clk;
        end
    end

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int expect_cnt(input int ticks, input real half);
        return int'(ticks * TREF / (2.0 * half));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic ext_write(input bit run, input int ticks);
        @(negedge clk);
        ext_we    = 1'b1;
        ext_wdata = {run, TICK_W'(ticks)};
        @(negedge clk);
        ext_we    = 1'b0;
        ext_wdata = '0;
    endtask

    task automatic wait_flag(input bit v);
        while (status[CNT_W] != v) @(negedge clk);
    endtask

    task automatic raw_measure(input int ticks, output int c);
        ext_write(1'b0, ticks);
        check(status[CNT_W] == 1'b1, "R2", int'(status[CNT_W]), 1);
        wait_flag(1'b0);
        ext_write(1'b1, ticks);
        wait_flag(1'b1);
        c = int'(status[CNT_W-1:0]);
    endtask

    task automatic push_exp(input int cnt, input int tol, input bit off);
        exp_t e;
        e.cnt = cnt; e.tol = tol; e.off = off;
        sb_q.push_back(e);
        pushed++;
    endtask

    task automatic pulse_go();
        @(negedge clk);
        probe_go = 1'b1;
        @(negedge clk);
        probe_go = 1'b0;
    endtask

    task automatic wait_result();
        while (!probe_valid) @(negedge clk);
        @(negedge clk);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        exp_t e;
        if (!rst && probe_valid) begin
            valid_seen++;
            if (sb_q.size() == 0) begin
                check(1'b0, "R10", valid_seen, pushed);
            end else begin
                e = sb_q.pop_front();
                check(iabs(int'(probe_count) - e.cnt) <= e.tol, "R7", int'(probe_count), e.cnt);
                check(probe_off == e.off, "R8", int'(probe_off), int'(e.off));
            end
        end
    end

    initial begin
        #(8 * 100000);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int c1, c2, c3;
        repeat (5) @(negedge clk);
        // R1: reset state
        check(status == '0, "R1", int'(status), 0);
        check(probe_busy == 1'b0, "R1", int'(probe_busy), 0);
        check(probe_valid == 1'b0, "R1", int'(probe_valid), 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // R3: direct measurement, 6 ns measured period
        raw_measure(64, c1);
        check(iabs(c1 - expect_cnt(64, 3.0)) <= 2, "R3", c1, expect_cnt(64, 3.0));

        // R4: run command while done is ignored
        ext_write(1'b1, 64);
        repeat (3) @(negedge clk);
        check(status[CNT_W] == 1'b1, "R4", int'(status[CNT_W]), 1);
        check(int'(status[CNT_W-1:0]) == c1, "R4", int'(status[CNT_W-1:0]), c1);

        // R3: second direct measurement (clear between runs), 8 ns period
        mhalf = 4.0;
        repeat (4) @(negedge clk);
        raw_measure(32, c3);
        check(iabs(c3 - expect_cnt(32, 4.0)) <= 2, "R3", c3, expect_cnt(32, 4.0));

        // R6: stopped clock keeps stale count
        m_run = 1'b0;
        repeat (4) @(negedge clk);
        raw_measure(64, c2);
        check(c2 == c3, "R6", c2, c3);

        // R8: probe on a stopped clock reports off
        push_exp(c3, 0, 1'b1);
        pulse_go();
        wait_result();

        // R7: running clocks at three periods
        m_run = 1'b1;
        mhalf = 3.0;
        repeat (4) @(negedge clk);
        push_exp(expect_cnt(FULL, 3.0), 2, 1'b0);
        pulse_go();
        wait_result();

        mhalf = 5.0;
        repeat (4) @(negedge clk);
        push_exp(expect_cnt(FULL, 5.0), 2, 1'b0);
        pulse_go();
        wait_result();

        // R9 / R10: interference while the probe is busy
        mhalf = 4.0;
        repeat (4) @(negedge clk);
        push_exp(expect_cnt(FULL, 4.0), 2, 1'b0);
        pulse_go();
        repeat (60) @(negedge clk);
        check(probe_busy == 1'b1, "R9", int'(probe_busy), 1);
        ext_write(1'b0, 5);
        pulse_go();
        wait_result();
        repeat (400) @(negedge clk);
        check(valid_seen == pushed, "R10", valid_seen, pushed);
        check(probe_busy == 1'b0, "R10", int'(probe_busy), 0);
        check(sb_q.size() == 0, "R7", sb_q.size(), 0);

        finish_run();
    end
endmodule